// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is one channel of a first-in first-out buffer that holds 256 words of 9 bits. The writer and the reader run on unrelated clocks. Besides the exact full and empty flags, it drives an almost-full flag and an almost-empty flag. Each of those flags compares the fill level against a threshold that software can program.

The thresholds sit in four small offset registers. No separate configuration bus reaches them. The host pulls the load strobe low and uses the ordinary data ports. A write enable with the strobe low stores the write-bus word into the offset register that is currently selected. A read enable with the strobe low returns the selected offset register on the read bus. After each access the selection steps through a fixed cycle of four registers and then wraps round. The write pointer and the read pointer cross between the two clock domains as Gray codes through two-flop synchronizers. A flag can therefore be released a few cycles late, but never early.

Top module: `pfifo_top`

## Requirements
- R1: With `ld_n` high, a write-clock edge with `wen_n` low stores `wdata` as a FIFO word. With `wen_n` high, the edge does nothing.
- R2: With `ld_n` low, a write-clock edge with `wen_n` low stores the write bus into the selected offset register, and no FIFO word is added. The write selection steps through empty-low (0), empty-high (1), full-low (2), full-high (3) and then wraps to 0.
- R3: With `ld_n` low, a read-clock edge with `ren_n` low returns the selected offset register on `rdata` in the following cycle. The read pointer does not move. The read selection follows the same four-step wrapping order as the write selection.
- R4: Reset sets each threshold to 7 and points both selections at empty-low. An offset readback after reset therefore gives 7, 0, 7, 0.
- R5: A threshold is 9 bits wide. The low register holds bits 7:0, taken from write-bus bits 7:0. The high register holds bit 8, taken from write-bus bit 0. The other write-bus bits are ignored and read back as 0.
- R6: `full_n` is low when 256 words are stored. With no reads after reset, it falls on the write edge of the 256th write. Writes while it is low are dropped.
- R7: `empty_n` is low when no word is stored. Reads while it is low are dropped, and `rdata` keeps its value.
- R8: `aempty_n` is low while the word count seen by the read side is at or below the empty threshold.
- R9: `afull_n` is low while the free space seen by the write side (256 minus the count) is at or below the full threshold. It returns high once reads have been synchronized back to the write side.
- R10: Words come out in the order they were written, across pointer wrap. Each accepted read presents its word on `rdata` one read-clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| ld_n | input | 1 | Active-low strobe that redirects port accesses to the offset registers |
| wen_n | input | 1 | Active-low write enable |
| wdata | input | 9 | Write data or offset value |
| ren_n | input | 1 | Active-low read enable |
| rdata | output | 9 | Registered read data or offset value |
| full_n | output | 1 | Active-low full flag, write-clock domain |
| afull_n | output | 1 | Active-low almost-full flag, write-clock domain |
| empty_n | output | 1 | Active-low empty flag, read-clock domain |
| aempty_n | output | 1 | Active-low almost-empty flag, read-clock domain |

## Verification
Some properties hold on every edge, and the assertions check those. A write while full or a read while empty leaves its pointer unchanged. An offset access never moves a FIFO pointer. With write enable inactive the write pointer holds. A full flag always comes with an almost-full flag, and an empty flag always comes with an almost-empty flag. Other behaviour only shows up through the bench's scenarios: the rotating register order, the reset defaults, the ignored upper bits, the exact write count at which each flag falls, and the preservation of data order across wrap, all checked against counts the bench works out itself.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    localparam int DATA_W      = 9;
    localparam int FIFO_DEPTH  = 256;
    localparam int SYNC_STAGES = 2;
    localparam logic [7:0] OFS_RESET_LO = 8'h07;

    typedef enum logic [1:0] {
        SEL_EMPTY_LO = 2'd0,
        SEL_EMPTY_HI = 2'd1,
        SEL_FULL_LO  = 2'd2,
        SEL_FULL_HI  = 2'd3
    } ofs_sel_e;

    typedef enum logic [1:0] {
        WOP_IDLE = 2'd0,
        WOP_PUSH = 2'd1,
        WOP_OFS  = 2'd2
    } wr_op_e;

    typedef enum logic [1:0] {
        ROP_IDLE = 2'd0,
        ROP_POP  = 2'd1,
        ROP_OFS  = 2'd2
    } rd_op_e;

    function automatic wr_op_e decode_wr(input logic ld_n, input logic wen_n);
        if (wen_n)     return WOP_IDLE;
        else if (ld_n) return WOP_PUSH;
        else           return WOP_OFS;
    endfunction

    function automatic rd_op_e decode_rd(input logic ld_n, input logic ren_n);
        if (ren_n)     return ROP_IDLE;
        else if (ld_n) return ROP_POP;
        else           return ROP_OFS;
    endfunction

    function automatic ofs_sel_e next_sel(input ofs_sel_e s);
        logic [1:0] t;
        t = s;
        t = t + 2'd1;
        return ofs_sel_e'(t);
    endfunction

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/pfifo_sync.sv
module pfifo_sync #(
    parameter int W      = 9,
    parameter int STAGES = pfifo_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                chain[s] <= chain[s-1];
            end
            chain[0] <= d;
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pfifo_ofs_regs.sv
module pfifo_ofs_regs #(
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wr_ofs,
    input  logic [7:0]    din,
    output logic [AW:0]   empty_ofs,
    output logic [AW:0]   full_ofs
);
    import pfifo_pkg::*;

    localparam int OFW  = AW + 1;
    localparam int HI_W = OFW - 8;

    ofs_sel_e        sel;
    logic [7:0]      e_lo, f_lo;
    logic [HI_W-1:0] e_hi, f_hi;

    always_ff @(posedge wclk) begin
        if (rst) begin
            sel  <= SEL_EMPTY_LO;
            e_lo <= OFS_RESET_LO;
            f_lo <= OFS_RESET_LO;
            e_hi <= '0;
            f_hi <= '0;
        end else if (wr_ofs) begin
            case (sel)
                SEL_EMPTY_LO: e_lo <= din;
                SEL_EMPTY_HI: e_hi <= din[HI_W-1:0];
                SEL_FULL_LO:  f_lo <= din;
                default:      f_hi <= din[HI_W-1:0];
            endcase
            sel <= next_sel(sel);
        end
    end

    assign empty_ofs = {e_hi, e_lo};
    assign full_ofs  = {f_hi, f_lo};
endmodule

// File: rtl/pfifo_ofs_view.sv
module pfifo_ofs_view #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          rd_ofs,
    input  logic [AW:0]   empty_ofs,
    input  logic [AW:0]   full_ofs,
    output logic [DW-1:0] ofs_word
);
    import pfifo_pkg::*;

    localparam int OFW = AW + 1;

    ofs_sel_e sel;

    always_ff @(posedge rclk) begin
        if (rst)         sel <= SEL_EMPTY_LO;
        else if (rd_ofs) sel <= next_sel(sel);
    end

    always_comb begin
        case (sel)
            SEL_EMPTY_LO: ofs_word = DW'(empty_ofs[7:0]);
            SEL_EMPTY_HI: ofs_word = DW'(empty_ofs[OFW-1:8]);
            SEL_FULL_LO:  ofs_word = DW'(full_ofs[7:0]);
            default:      ofs_word = DW'(full_ofs[OFW-1:8]);
        endcase
    end
endmodule

// File: rtl/pfifo_wr_side.sv
module pfifo_wr_side #(
    parameter int AW = 8
) (
    input  logic        wclk,
    input  logic        rst,
    input  logic        push_req,
    input  logic [AW:0] rgray_s,
    input  logic [AW:0] full_ofs,
    output logic        push,
    output logic [AW:0] wbin,
    output logic [AW:0] wgray,
    output logic        full_n,
    output logic        afull_n
);
    import pfifo_pkg::*;

    localparam int PW = AW + 1;
    localparam logic [PW-1:0] CAP = PW'(1) << AW;

    logic [PW-1:0] rbin_s, used, free, wbin_nxt;

    always_comb begin
        rbin_s   = PW'(gray2bin(32'(rgray_s)));
        used     = wbin - rbin_s;
        free     = CAP - used;
        full_n   = ~used[AW];
        afull_n  = ~(free <= full_ofs);
        push     = push_req & full_n;
        wbin_nxt = wbin + PW'(push);
    end

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= PW'(bin2gray(32'(wbin_nxt)));
        end
    end
endmodule

// File: rtl/pfifo_rd_side.sv
module pfifo_rd_side #(
    parameter int AW = 8
) (
    input  logic        rclk,
    input  logic        rst,
    input  logic        pop_req,
    input  logic [AW:0] wgray_s,
    input  logic [AW:0] empty_ofs,
    output logic        pop,
    output logic [AW:0] rbin,
    output logic [AW:0] rgray,
    output logic        empty_n,
    output logic        aempty_n
);
    import pfifo_pkg::*;

    localparam int PW = AW + 1;

    logic [PW-1:0] wbin_s, used, rbin_nxt;

    always_comb begin
        wbin_s   = PW'(gray2bin(32'(wgray_s)));
        used     = wbin_s - rbin;
        empty_n  = (used != '0);
        aempty_n = ~(used <= empty_ofs);
        pop      = pop_req & empty_n;
        rbin_nxt = rbin + PW'(pop);
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= PW'(bin2gray(32'(rbin_nxt)));
        end
    end
endmodule

// File: rtl/pfifo_ram.sv
module pfifo_ram #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign q = mem[raddr];
endmodule

// File: rtl/pfifo_top.sv
module pfifo_top #(
    parameter int DW    = pfifo_pkg::DATA_W,
    parameter int DEPTH = pfifo_pkg::FIFO_DEPTH
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          wen_n,
    input  logic [DW-1:0] wdata,
    input  logic          ren_n,
    output logic [DW-1:0] rdata,
    output logic          full_n,
    output logic          afull_n,
    output logic          empty_n,
    output logic          aempty_n
);
    import pfifo_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    wr_op_e        wop;
    rd_op_e        rop;
    logic          push, pop;
    logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PW-1:0] wr_gray_s, rd_gray_s;
    logic [PW-1:0] empty_ofs, full_ofs;
    logic [DW-1:0] ram_q, ofs_word;

    always_comb begin
        wop = decode_wr(ld_n, wen_n);
        rop = decode_rd(ld_n, ren_n);
    end

    pfifo_ofs_regs #(.AW(AW)) u_regs (
        .wclk      (wclk),
        .rst       (rst),
        .wr_ofs    (wop == WOP_OFS),
        .din       (wdata[7:0]),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    pfifo_ofs_view #(.AW(AW), .DW(DW)) u_view (
        .rclk      (rclk),
        .rst       (rst),
        .rd_ofs    (rop == ROP_OFS),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .ofs_word  (ofs_word)
    );

    pfifo_wr_side #(.AW(AW)) u_wr (
        .wclk     (wclk),
        .rst      (rst),
        .push_req (wop == WOP_PUSH),
        .rgray_s  (rd_gray_s),
        .full_ofs (full_ofs),
        .push     (push),
        .wbin     (wr_bin),
        .wgray    (wr_gray),
        .full_n   (full_n),
        .afull_n  (afull_n)
    );

    pfifo_rd_side #(.AW(AW)) u_rd (
        .rclk      (rclk),
        .rst       (rst),
        .pop_req   (rop == ROP_POP),
        .wgray_s   (wr_gray_s),
        .empty_ofs (empty_ofs),
        .pop       (pop),
        .rbin      (rd_bin),
        .rgray     (rd_gray),
        .empty_n   (empty_n),
        .aempty_n  (aempty_n)
    );

    pfifo_sync #(.W(PW)) u_w2r (
        .clk (rclk),
        .rst (rst),
        .d   (wr_gray),
        .q   (wr_gray_s)
    );

    pfifo_sync #(.W(PW)) u_r2w (
        .clk (wclk),
        .rst (rst),
        .d   (rd_gray),
        .q   (rd_gray_s)
    );

    pfifo_ram #(.AW(AW), .DW(DW)) u_ram (
        .wclk  (wclk),
        .we    (push),
        .waddr (wr_bin[AW-1:0]),
        .wdata (wdata),
        .raddr (rd_bin[AW-1:0]),
        .q     (ram_q)
    );

    always_ff @(posedge rclk) begin
        if (rst)                rdata <= '0;
        else if (pop)           rdata <= ram_q;
        else if (rop == ROP_OFS) rdata <= ofs_word;
    end
endmodule

// File: rtl/pfifo_chk.sv
module pfifo_chk #(
    parameter int PW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          ld_n,
    input logic          wen_n,
    input logic          ren_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic [PW-1:0] wr_bin,
    input logic [PW-1:0] rd_bin
);
    // R6
    no_overflow_chk: assert property (@(posedge wclk) disable iff (rst)
        (!full_n && ld_n && !wen_n) |=> $stable(wr_bin));

    // R7
    no_underflow_chk: assert property (@(posedge rclk) disable iff (rst)
        (!empty_n && ld_n && !ren_n) |=> $stable(rd_bin));

    // R2
    ofs_write_no_push_chk: assert property (@(posedge wclk) disable iff (rst)
        (!ld_n) |=> $stable(wr_bin));

    // R3
    ofs_read_no_pop_chk: assert property (@(posedge rclk) disable iff (rst)
        (!ld_n) |=> $stable(rd_bin));

    // R1
    idle_write_chk: assert property (@(posedge wclk) disable iff (rst)
        wen_n |=> $stable(wr_bin));

    // R9
    full_implies_afull_chk: assert property (@(posedge wclk) disable iff (rst)
        !full_n |-> !afull_n);

    // R8
    empty_implies_aempty_chk: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |-> !aempty_n);
endmodule

bind pfifo_top pfifo_chk #(.PW(PW)) u_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst      (rst),
    .ld_n     (ld_n),
    .wen_n    (wen_n),
    .ren_n    (ren_n),
    .full_n   (full_n),
    .afull_n  (afull_n),
    .empty_n  (empty_n),
    .aempty_n (aempty_n),
    .wr_bin   (wr_bin),
    .rd_bin   (rd_bin)
);

// File: tb/pfifo_top_test.sv
module pfifo_top_test;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DW          = 9;
    localparam int DEPTH       = 256;
    localparam int E_OFS       = 20;
    localparam int F_OFS       = 30;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst  = 1'b1;
    logic          ld_n = 1'b1;
    logic          wen_n = 1'b1;
    logic          ren_n = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          full_n, afull_n, empty_n, aempty_n;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2)  wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    pfifo_top #(.DW(DW), .DEPTH(DEPTH)) uut (
        .wclk     (wclk),
        .rclk     (rclk),
        .rst      (rst),
        .ld_n     (ld_n),
        .wen_n    (wen_n),
        .wdata    (wdata),
        .ren_n    (ren_n),
        .rdata    (rdata),
        .full_n   (full_n),
        .afull_n  (afull_n),
        .empty_n  (empty_n),
        .aempty_n (aempty_n)
    );

    function automatic logic [DW-1:0] pattern(input int i);
        return DW'((i * 37 + 5) % 512);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge wclk);
        ld_n = 1'b1; wen_n = 1'b0; wdata = v;
        @(negedge wclk);
        wen_n = 1'b1;
    endtask

    task automatic ofs_write(input logic [DW-1:0] v);
        @(negedge wclk);
        ld_n = 1'b0; wen_n = 1'b0; wdata = v;
        @(negedge wclk);
        wen_n = 1'b1; ld_n = 1'b1;
    endtask

    task automatic pop(output logic [DW-1:0] v);
        @(negedge rclk);
        ld_n = 1'b1; ren_n = 1'b0;
        @(negedge rclk);
        ren_n = 1'b1;
        v = rdata;
    endtask

    task automatic ofs_read(output logic [DW-1:0] v);
        @(negedge rclk);
        ld_n = 1'b0; ren_n = 1'b0;
        @(negedge rclk);
        ren_n = 1'b1; ld_n = 1'b1;
        v = rdata;
    endtask

    task automatic wait_r(input int n);
        for (int k = 0; k < n; k++) @(negedge rclk);
    endtask

    task automatic wait_w(input int n);
        for (int k = 0; k < n; k++) @(negedge wclk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] last;
        int cnt;

        wait_r(6);
        @(negedge wclk);
        rst = 1'b0;
        wait_r(4);

        // Reset state of flags (R6, R7, R8, R9)
        check(full_n == 1'b1,   "R6 reset full_n",   full_n, 1);
        check(afull_n == 1'b1,  "R9 reset afull_n",  afull_n, 1);
        check(empty_n == 1'b0,  "R7 reset empty_n",  empty_n, 0);
        check(aempty_n == 1'b0, "R8 reset aempty_n", aempty_n, 0);

        // R4: default thresholds read back 7,0,7,0
        for (int k = 0; k < 4; k++) begin
            ofs_read(v);
            check(v == ((k % 2 == 0) ? 9'h007 : 9'h000), "R4 default readback", v, (k % 2 == 0) ? 7 : 0);
        end

        // R2 / R5: program thresholds, upper bits of the high parts are ignored
        ofs_write(9'(E_OFS));
        ofs_write(9'h1FE);
        ofs_write(9'(F_OFS));
        ofs_write(9'h1FE);
        wait_r(4);
        check(empty_n == 1'b0, "R2 offset writes add no word", empty_n, 0);

        // R3 / R5: readback in rotating order, then wrap to the first register
        ofs_read(v); check(v == 9'(E_OFS), "R3 empty low readback", v, E_OFS);
        ofs_read(v); check(v == 9'h000,    "R5 empty high ignores upper bits", v, 0);
        ofs_read(v); check(v == 9'(F_OFS), "R3 full low readback", v, F_OFS);
        ofs_read(v); check(v == 9'h000,    "R5 full high ignores upper bits", v, 0);
        ofs_read(v); check(v == 9'(E_OFS), "R3 select wraps", v, E_OFS);
        check(empty_n == 1'b0, "R3 offset reads take no word", empty_n, 0);
        ofs_read(v); ofs_read(v); ofs_read(v);

        // R1: write enable inactive does nothing
        @(negedge wclk);
        ld_n = 1'b1; wdata = 9'h0AA;
        wait_w(3);
        wait_r(4);
        check(empty_n == 1'b0, "R1 idle write adds nothing", empty_n, 0);

        // R6 / R9: fill with no reads
        for (int i = 0; i < DEPTH; i++) begin
            push(pattern(i));
            cnt = i + 1;
            check(full_n == (cnt < DEPTH), "R6 full flag during fill", full_n, cnt < DEPTH);
            check(afull_n == ((DEPTH - cnt) > F_OFS), "R9 almost-full during fill", afull_n, (DEPTH - cnt) > F_OFS);
        end
        push(9'h155);
        check(full_n == 1'b0, "R6 write while full keeps full", full_n, 0);

        wait_r(6);
        check(empty_n == 1'b1,  "R7 not empty after fill", empty_n, 1);
        check(aempty_n == 1'b1, "R8 not almost-empty after fill", aempty_n, 1);

        // R10 / R7 / R8: drain and compare order
        last = '0;
        for (int k = 1; k <= DEPTH; k++) begin
            pop(v);
            last = v;
            cnt = DEPTH - k;
            check(v == pattern(k - 1), "R10 data order", v, pattern(k - 1));
            check(empty_n == (cnt != 0), "R7 empty flag during drain", empty_n, cnt != 0);
            check(aempty_n == (cnt > E_OFS), "R8 almost-empty during drain", aempty_n, cnt > E_OFS);
        end

        // R7: read while empty is dropped and rdata holds
        pop(v);
        check(v == last,       "R7 read while empty holds rdata", v, last);
        check(empty_n == 1'b0, "R7 still empty", empty_n, 0);

        // R9: flags release on the write side after synchronization
        wait_w(6);
        check(full_n == 1'b1,  "R6 full released", full_n, 1);
        check(afull_n == 1'b1, "R9 almost-full released", afull_n, 1);

        // R10: data across pointer wrap
        for (int i = 0; i < 3; i++) push(pattern(300 + i));
        wait_r(6);
        check(aempty_n == 1'b0, "R8 three words below threshold", aempty_n, 0);
        for (int i = 0; i < 3; i++) begin
            pop(v);
            check(v == pattern(300 + i), "R10 data after wrap", v, pattern(300 + i));
        end
        check(empty_n == 1'b0, "R7 empty after wrap drain", empty_n, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule